// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the software-visible register file of a four-channel DMA controller. A host reaches it through a byte-wide port with separate read and write strobes. Eight low register indices hold each channel's 16-bit start address and start count; both are loaded and read one byte at a time. The byte order comes from a single toggle shared by every channel register access. Eight upper indices carry the controller-wide operations: command, software request, per-channel mask set/clear, channel mode, toggle clear, master reset, unmask-all and load-all-masks. A status register clears its low nibble when it is read.

The parameter `SHIFT` sets the spacing of the ports. With `SHIFT = 0` the registers sit on consecutive byte addresses and channel addresses are byte addresses. With `SHIFT = 1` they sit on every other address, and the stored address is scaled by two for word-wide transfers. The transfer engine reads the current address, start count, mode, mask and request outputs. It reports progress back through a transferred-count update and per-channel terminal-count pulses. Bus transfers themselves live in the engine.

Top module: `dmac_regfile`

## Requirements
- R1: The register index is bits [3:0] of `port_addr >> SHIFT`. Indices 0..7 are channel registers: the channel is index >> 1, and index bit 0 chooses the start address (0) or the start count (1).
- R2: Every channel register read or write uses the byte toggle (0 = low byte, 1 = high byte) and then inverts it. A write to index 12 clears the toggle.
- R3: Writing the high byte of either start register reloads the channel. The current address becomes start address << SHIFT, and the transferred count becomes 0.
- R4: An address read returns byte bits [SHIFT+8*toggle+7 : SHIFT+8*toggle] of (current address + transferred). A count read takes the same byte of ((start count << SHIFT) − transferred). Both values are AW = 16+SHIFT bits wide and wrap.
- R5: A write to index 8 loads the command register when the data is zero or sets no bit other than bit 2. Any other value leaves the command register unchanged.
- R6: A write to index 9 sets status bit (4 + data[1:0]) to data[2] and clears status bit data[1:0].
- R7: A write to index 10 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. A write to index 11 stores the whole byte as the mode of channel data[1:0].
- R8: A write to index 13 clears the toggle, status and command and sets all eight mask bits. Reset leaves the same state, with modes, start registers, current addresses and transferred counts at 0. A write to index 14 clears all mask bits. A write to index 15 loads all eight mask bits from the data.
- R9: A read of index 8 returns status and then clears status bits [3:0]. A read of index 15 returns the 8-bit mask. Reads of indices 9 to 14 return 0 and change nothing.
- R10: A pulse on `tc_set[c]` sets status bit c, and it wins over a clear in the same cycle. A pulse on `xfer_upd[c]` loads `xfer_val` as channel c's transferred count, unless a high-byte write to that channel reloads it in the same cycle.
- R11: When `wr_en` and `rd_en` are both high, only the write takes effect and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_addr | input | PORT_W | Host port address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, combinational while `rd_en` is high |
| tc_set | input | 4 | Terminal-count pulses from the engine |
| xfer_upd | input | 4 | Transferred-count load strobes from the engine |
| xfer_val | input | AW | Transferred count value |
| cur_addr_o | output | 4*AW | Current address per channel |
| base_cnt_o | output | 64 | Start count per channel |
| mode_o | output | 32 | Mode byte per channel |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Request bits (status [7:4]) |
| command_o | output | 8 | Command register |

## Verification
The hardest states to reach are those where the shared byte toggle no longer lines up with the register being accessed. Examples are a count read after an odd number of address accesses on another channel, or a high-byte write that reloads the channel while the engine has already reported a transferred count. The random stream mixes channel accesses, toggle clears, master resets, engine count updates and terminal-count pulses without restoring alignment. A bench model tracks the toggle and predicts every returned byte. Directed cases cover rejected command values, a write and read in the same cycle, and the clear-on-read of status with a pending request bit.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int NCH = 4;
   localparam logic [3:0] IDX_CMD   = 4'd8;
   localparam logic [3:0] IDX_REQ   = 4'd9;
   localparam logic [3:0] IDX_SMASK = 4'd10;
   localparam logic [3:0] IDX_MODE  = 4'd11;
   localparam logic [3:0] IDX_CLRFF = 4'd12;
   localparam logic [3:0] IDX_MRST  = 4'd13;
   localparam logic [3:0] IDX_CLRM  = 4'd14;
   localparam logic [3:0] IDX_WMASK = 4'd15;
   // command bits that may be set; any other set bit rejects the write
   localparam logic [7:0] CMD_ALLOWED = 8'h04;
   localparam logic [7:0] MASK_RESET  = 8'hFF;
endpackage

// File: rtl/dmac_parts.sv
// Address decode: register index, channel select and qualified strobes.
module dmac_decode #(
   parameter int SHIFT  = 0,
   parameter int PORT_W = 8
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [PORT_W-1:0] port_addr,
   output logic [3:0]        idx,
   output logic              chan_wr,
   output logic              chan_rd,
   output logic              ctl_wr,
   output logic              ctl_rd,
   output logic [1:0]        ch_sel,
   output logic              sel_cnt
);
   logic [PORT_W-1:0] shifted;
   logic              rd_eff;

   assign shifted = port_addr >> SHIFT;
   assign idx     = shifted[3:0];
   assign ch_sel  = idx[2:1];
   assign sel_cnt = idx[0];
   assign rd_eff  = rd_en & ~wr_en;          // write wins
   assign chan_wr = wr_en  & ~idx[3];
   assign chan_rd = rd_eff & ~idx[3];
   assign ctl_wr  = wr_en  &  idx[3];
   assign ctl_rd  = rd_eff &  idx[3];
endmodule

// One channel: start registers, current address, transferred count.
module dmac_chan #(
   parameter int SHIFT = 0,
   parameter int AW    = 16 + SHIFT
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic          sel_cnt,
   input  logic [7:0]    wr_data,
   input  logic          xfer_upd,
   input  logic [AW-1:0] xfer_val,
   output logic [15:0]   base_cnt_o,
   output logic [AW-1:0] cur_addr_o,
   output logic [AW-1:0] addr_rd_o,
   output logic [AW-1:0] cnt_rd_o
);
   logic [15:0]   base_addr_q, base_cnt_q, next_base_addr;
   logic [AW-1:0] cur_q, xf_q;

   assign next_base_addr = sel_cnt ? base_addr_q : {wr_data, base_addr_q[7:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr_q <= '0;
         base_cnt_q  <= '0;
         cur_q       <= '0;
         xf_q        <= '0;
      end else begin
         if (wr_lo) begin
            if (sel_cnt) base_cnt_q[7:0]  <= wr_data;
            else         base_addr_q[7:0] <= wr_data;
         end
         if (wr_hi) begin
            if (sel_cnt) base_cnt_q[15:8]  <= wr_data;
            else         base_addr_q[15:8] <= wr_data;
            cur_q <= AW'(next_base_addr) << SHIFT;
            xf_q  <= '0;
         end else if (xfer_upd) begin
            xf_q <= xfer_val;
         end
      end
   end

   assign base_cnt_o = base_cnt_q;
   assign cur_addr_o = cur_q;
   assign addr_rd_o  = cur_q + xf_q;
   assign cnt_rd_o   = (AW'(base_cnt_q) << SHIFT) - xf_q;
endmodule

// Controller-wide registers: command, mask, status, modes, byte toggle.
module dmac_ctrl
   import dmac_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_rd,
   input  logic             chan_acc,
   input  logic [3:0]       idx,
   input  logic [7:0]       wr_data,
   input  logic [NCH-1:0]   tc_set,
   output logic [7:0]       command_o,
   output logic [7:0]       mask_o,
   output logic [7:0]       status_o,
   output logic             flip_o,
   output logic [NCH*8-1:0] mode_o,
   output logic [7:0]       ctl_rdata
);
   logic [7:0] cmd_q, mask_q, st_q, st_n;
   logic       ff_q;
   logic [7:0] mode_q [NCH];
   logic       cmd_ok;

   assign cmd_ok = (wr_data == 8'h00) || ((wr_data & ~CMD_ALLOWED) == 8'h00);

   always_comb begin
      st_n = st_q;
      if (ctl_wr && idx == IDX_REQ) begin
         st_n[{1'b1, wr_data[1:0]}] = wr_data[2];
         st_n[{1'b0, wr_data[1:0]}] = 1'b0;
      end
      if (ctl_wr && idx == IDX_MRST) st_n = '0;
      if (ctl_rd && idx == IDX_CMD)  st_n[3:0] = 4'h0;
      st_n[3:0] = st_n[3:0] | tc_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         mask_q <= MASK_RESET;
         st_q   <= '0;
         ff_q   <= 1'b0;
      end else begin
         st_q <= st_n;
         if (ctl_wr && (idx == IDX_CLRFF || idx == IDX_MRST)) ff_q <= 1'b0;
         else if (chan_acc)                                   ff_q <= ~ff_q;
         if (ctl_wr) begin
            unique case (idx)
               IDX_CMD:   if (cmd_ok) cmd_q <= wr_data;
               IDX_SMASK: mask_q[wr_data[1:0]] <= wr_data[2];
               IDX_MRST:  begin cmd_q <= '0; mask_q <= MASK_RESET; end
               IDX_CLRM:  mask_q <= '0;
               IDX_WMASK: mask_q <= wr_data;
               default:   ;
            endcase
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_mode
      always_ff @(posedge clk) begin
         if (!rst_n)                                                    mode_q[c] <= '0;
         else if (ctl_wr && idx == IDX_MODE && wr_data[1:0] == 2'(c))   mode_q[c] <= wr_data;
      end
      assign mode_o[c*8 +: 8] = mode_q[c];
   end

   always_comb begin
      ctl_rdata = 8'h00;
      if (idx == IDX_CMD)   ctl_rdata = st_q;
      if (idx == IDX_WMASK) ctl_rdata = mask_q;
   end

   assign command_o = cmd_q;
   assign mask_o    = mask_q;
   assign status_o  = st_q;
   assign flip_o    = ff_q;
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_pkg::*;
#(
   parameter  int SHIFT  = 0,
   parameter  int PORT_W = 8,
   localparam int AW     = 16 + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [PORT_W-1:0] port_addr,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic [NCH-1:0]   tc_set,
   input  logic [NCH-1:0]   xfer_upd,
   input  logic [AW-1:0]    xfer_val,
   output logic [NCH*AW-1:0] cur_addr_o,
   output logic [NCH*16-1:0] base_cnt_o,
   output logic [NCH*8-1:0] mode_o,
   output logic [NCH-1:0]   mask_o,
   output logic [NCH-1:0]   req_o,
   output logic [7:0]       command_o
);
   if (SHIFT < 0 || SHIFT > 1) begin : g_bad_shift
      $error("dmac_regfile: SHIFT must be 0 or 1");
   end
   if (PORT_W < 4 + SHIFT) begin : g_bad_port
      $error("dmac_regfile: PORT_W too narrow for the register index");
   end

   logic [3:0]    idx;
   logic          chan_wr, chan_rd, ctl_wr, ctl_rd, sel_cnt;
   logic [1:0]    ch_sel;
   logic          flip;
   logic [7:0]    status_q, mask_full, ctl_rdata;
   logic [AW-1:0] addr_rd [NCH];
   logic [AW-1:0] cnt_rd  [NCH];
   logic [AW-1:0] chan_val, chan_shifted;

   dmac_decode #(.SHIFT(SHIFT), .PORT_W(PORT_W)) u_dec (
      .wr_en(wr_en), .rd_en(rd_en), .port_addr(port_addr), .idx(idx),
      .chan_wr(chan_wr), .chan_rd(chan_rd), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
      .ch_sel(ch_sel), .sel_cnt(sel_cnt)
   );

   dmac_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
      .chan_acc(chan_wr | chan_rd), .idx(idx), .wr_data(wr_data),
      .tc_set(tc_set), .command_o(command_o), .mask_o(mask_full),
      .status_o(status_q), .flip_o(flip), .mode_o(mode_o), .ctl_rdata(ctl_rdata)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic hit;
      assign hit = chan_wr && (ch_sel == 2'(c));
      dmac_chan #(.SHIFT(SHIFT), .AW(AW)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(hit & ~flip), .wr_hi(hit & flip), .sel_cnt(sel_cnt),
         .wr_data(wr_data), .xfer_upd(xfer_upd[c]), .xfer_val(xfer_val),
         .base_cnt_o(base_cnt_o[c*16 +: 16]), .cur_addr_o(cur_addr_o[c*AW +: AW]),
         .addr_rd_o(addr_rd[c]), .cnt_rd_o(cnt_rd[c])
      );
   end

   assign chan_val     = sel_cnt ? cnt_rd[ch_sel] : addr_rd[ch_sel];
   assign chan_shifted = chan_val >> (SHIFT + (flip ? 8 : 0));

   always_comb begin
      rd_data = 8'h00;
      if (chan_rd)     rd_data = chan_shifted[7:0];
      else if (ctl_rd) rd_data = ctl_rdata;
   end

   assign mask_o = mask_full[NCH-1:0];
   assign req_o  = status_q[7:4];
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
   parameter int SHIFT  = 0,
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [PORT_W-1:0] port_addr,
   input logic [7:0]        wr_data,
   input logic [3:0]        tc_set,
   input logic [7:0]        command_o,
   input logic [3:0]        mask_o,
   input logic [7:0]        status,
   input logic              flip
);
   logic [PORT_W-1:0] sh;
   logic [3:0]        ix;
   assign sh = port_addr >> SHIFT;
   assign ix = sh[3:0];

   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !ix[3]) |=> (flip != $past(flip)));

   assert_clear_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == 4'd12) |=> !flip);

   assert_cmd_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == 4'd8 && wr_data != 8'h00 && (wr_data & 8'hFB) != 8'h00)
      |=> $stable(command_o));

   assert_master_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == 4'd13 && tc_set == 4'h0)
      |=> (mask_o == 4'hF && command_o == 8'h00 && status == 8'h00 && !flip));

   assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && ix == 4'd8 && tc_set == 4'h0) |=> (status[3:0] == 4'h0));
endmodule

bind dmac_regfile dmac_regfile_chk #(.SHIFT(SHIFT), .PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_addr(port_addr),
   .wr_data(wr_data), .tc_set(tc_set), .command_o(command_o), .mask_o(mask_o),
   .status(status_q), .flip(flip)
);

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
   localparam int CLK_PERIOD = 10;
   localparam int SH = 1;
   localparam int PW = 8;
   localparam int AW = 16 + SH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [PW-1:0] port_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic [3:0]    tc_set = '0, xfer_upd = '0;
   logic [AW-1:0] xfer_val = '0;
   logic [4*AW-1:0] cur_addr_o;
   logic [63:0]   base_cnt_o;
   logic [31:0]   mode_o;
   logic [3:0]    mask_o, req_o;
   logic [7:0]    command_o;

   dmac_regfile #(.SHIFT(SH), .PORT_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_addr(port_addr),
      .wr_data(wr_data), .rd_data(rd_data), .tc_set(tc_set), .xfer_upd(xfer_upd),
      .xfer_val(xfer_val), .cur_addr_o(cur_addr_o), .base_cnt_o(base_cnt_o),
      .mode_o(mode_o), .mask_o(mask_o), .req_o(req_o), .command_o(command_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model
   logic [15:0]   m_ba [4];
   logic [15:0]   m_bc [4];
   logic [AW-1:0] m_cur [4];
   logic [AW-1:0] m_xf [4];
   logic [7:0]    m_mode [4];
   logic [7:0]    m_cmd, m_mask, m_st;
   logic          m_ff;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 4; c++) begin
         m_ba[c] = 0; m_bc[c] = 0; m_cur[c] = 0; m_xf[c] = 0; m_mode[c] = 0;
      end
      m_cmd = 0; m_mask = 8'hFF; m_st = 0; m_ff = 0;
   endtask

   function automatic logic [7:0] model_read(input logic [3:0] ix);
      logic [AW-1:0] v;
      int c;
      c = int'(ix[2:1]);
      if (!ix[3]) begin
         if (ix[0]) v = (AW'(m_bc[c]) << SH) - m_xf[c];
         else       v = m_cur[c] + m_xf[c];
         v = v >> (SH + (m_ff ? 8 : 0));
         return v[7:0];
      end
      if (ix == 4'd8)  return m_st;
      if (ix == 4'd15) return m_mask;
      return 8'h00;
   endfunction

   task automatic model_update(input bit w, input bit r, input logic [3:0] ix, input logic [7:0] d);
      int c;
      c = int'(ix[2:1]);
      if (w) begin
         if (!ix[3]) begin
            if (m_ff) begin
               if (ix[0]) m_bc[c][15:8] = d; else m_ba[c][15:8] = d;
               m_cur[c] = AW'(m_ba[c]) << SH;
               m_xf[c]  = 0;
            end else begin
               if (ix[0]) m_bc[c][7:0] = d; else m_ba[c][7:0] = d;
            end
            m_ff = ~m_ff;
         end else begin
            case (ix)
               4'd8:  if (d == 0 || (d & 8'hFB) == 0) m_cmd = d;
               4'd9:  begin m_st[4 + d[1:0]] = d[2]; m_st[d[1:0]] = 1'b0; end
               4'd10: m_mask[d[1:0]] = d[2];
               4'd11: m_mode[d[1:0]] = d;
               4'd12: m_ff = 0;
               4'd13: begin m_ff = 0; m_mask = 8'hFF; m_st = 0; m_cmd = 0; end
               4'd14: m_mask = 0;
               default: m_mask = d;
            endcase
         end
      end else if (r) begin
         if (!ix[3]) m_ff = ~m_ff;
         else if (ix == 4'd8) m_st[3:0] = 4'h0;
      end
   endtask

   task automatic op(input bit w, input bit r, input logic [3:0] ix, input logic [7:0] d, input string tag);
      logic [7:0] e;
      @(negedge clk);
      wr_en = w; rd_en = r; port_addr = PW'(ix) << SH; wr_data = d;
      #1;
      if (r && w) check(rd_data == 8'h00, "R11 read data during write", rd_data, 0);
      else if (r) begin
         e = model_read(ix);
         check(rd_data == e, tag, rd_data, e);
      end
      @(posedge clk);
      model_update(w, r, ix, d);
      #1;
      wr_en = 0; rd_en = 0;
   endtask

   task automatic engine(input logic [3:0] tc, input logic [3:0] upd, input logic [AW-1:0] val);
      @(negedge clk);
      tc_set = tc; xfer_upd = upd; xfer_val = val;
      @(posedge clk);
      m_st[3:0] = m_st[3:0] | tc;
      for (int c = 0; c < 4; c++) if (upd[c]) m_xf[c] = val;
      #1;
      tc_set = 0; xfer_upd = 0;
   endtask

   task automatic check_outputs(input string tag);
      @(negedge clk);
      check(mask_o == m_mask[3:0], {tag, " R7 mask_o"}, mask_o, m_mask[3:0]);
      check(req_o == m_st[7:4], {tag, " R6 req_o"}, req_o, m_st[7:4]);
      check(command_o == m_cmd, {tag, " R5 command_o"}, command_o, m_cmd);
      for (int c = 0; c < 4; c++) begin
         check(cur_addr_o[c*AW +: AW] == m_cur[c], {tag, " R3 cur_addr_o"}, cur_addr_o[c*AW +: AW], m_cur[c]);
         check(mode_o[c*8 +: 8] == m_mode[c], {tag, " R7 mode_o"}, mode_o[c*8 +: 8], m_mode[c]);
         check(base_cnt_o[c*16 +: 16] == m_bc[c], {tag, " R1 base_cnt_o"}, base_cnt_o[c*16 +: 16], m_bc[c]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state (R8)
      check_outputs("R8 reset");
      op(0, 1, 4'd15, 0, "R8 mask after reset");
      op(0, 1, 4'd8, 0, "R8 status after reset");

      // R1/R2/R3: program channel 2 address and count, read back bytes
      op(1, 0, 4'd4, 8'h34, "R1");
      op(1, 0, 4'd4, 8'h92, "R3");
      op(1, 0, 4'd5, 8'h10, "R1");
      op(1, 0, 4'd5, 8'h00, "R3");
      check_outputs("R3 after reload");
      op(0, 1, 4'd4, 0, "R4 addr low");
      op(0, 1, 4'd4, 0, "R4 addr high");
      engine(4'h0, 4'b0100, 17'h00021);
      op(0, 1, 4'd5, 0, "R4 count low after transfer");
      op(0, 1, 4'd5, 0, "R4 count high after transfer");
      // toggle left high, then cleared
      op(0, 1, 4'd0, 0, "R2 misaligned read");
      op(1, 0, 4'd12, 0, "R2 clear toggle");
      op(0, 1, 4'd4, 0, "R2 low byte after clear");
      // R10: transfer update vs reload priority
      @(negedge clk);
      wr_en = 1; port_addr = PW'(4'd4) << SH; wr_data = 8'h55;
      xfer_upd = 4'b0100; xfer_val = 17'h1FFFF;
      @(posedge clk);
      model_update(1, 0, 4'd4, 8'h55);
      #1 wr_en = 0; xfer_upd = 0;
      op(0, 1, 4'd4, 0, "R10 reload beats transfer update");

      // R5 command
      op(1, 0, 4'd8, 8'h04, "R5");
      op(1, 0, 4'd8, 8'h05, "R5");
      op(1, 0, 4'd8, 8'h80, "R5");
      check_outputs("R5 reject");
      op(1, 0, 4'd8, 8'h00, "R5");
      check_outputs("R5 zero");

      // R6, R9, R10 status behaviour
      op(1, 0, 4'd9, 8'h05, "R6");
      engine(4'b1011, 4'h0, 0);
      op(0, 1, 4'd8, 0, "R9 status with tc and request");
      op(0, 1, 4'd8, 0, "R9 status low nibble cleared");
      op(1, 0, 4'd9, 8'h01, "R6");
      check_outputs("R6 request clear");
      op(0, 1, 4'd10, 0, "R9 other control read");

      // R7 mask and mode
      op(1, 0, 4'd14, 0, "R8");
      op(1, 0, 4'd10, 8'h07, "R7");
      op(1, 0, 4'd11, 8'hA6, "R7");
      check_outputs("R7");
      op(1, 0, 4'd15, 8'h5A, "R8");
      op(0, 1, 4'd15, 0, "R8 full mask read");
      op(1, 0, 4'd13, 0, "R8");
      check_outputs("R8 master reset");

      // R11 write and read together
      op(1, 1, 4'd1, 8'h3C, "R11");
      op(0, 1, 4'd1, 0, "R11 toggle after combined access");

      for (int i = 0; i < 3000; i++) begin
         int k;
         logic [3:0] ix;
         logic [7:0] d;
         k = int'($urandom % 10);
         d = 8'($urandom);
         case (k)
            0, 1, 2: op(1, 0, 4'($urandom % 8), d, "R1");
            3, 4:    op(0, 1, 4'($urandom % 8), 0, "R4 random channel read");
            5: begin
               ix = 4'(8 + $urandom % 8);
               if (ix == 4'd13 && ($urandom % 4) != 0) ix = 4'd12;
               if (ix == 4'd8 && ($urandom % 2) == 0) d = (($urandom % 2) == 0) ? 8'h00 : 8'h04;
               op(1, 0, ix, d, "R5");
            end
            6:       op(0, 1, 4'(8 + $urandom % 8), 0, "R9 random control read");
            7:       engine(4'h0, 4'(1 << ($urandom % 4)), AW'($urandom));
            8:       engine(4'($urandom), 4'h0, 0);
            default: check_outputs("random");
         endcase
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule